// File: doc/BRIEF.md
# Bank-Switched Expansion RAM Controller

This block holds the switching logic for a 16 KB RAM card that can replace the ROM seen by an 8-bit processor in the top 12 KB of its 64 KB address space (`$D000-$FFFF`). The card owns sixteen soft-switch locations. Slot decoding happens outside the block and arrives as a card-select input. Any bus cycle to a soft-switch location changes the card's state. That state has three parts: whether the overlay window is read from ROM or RAM, how far writes to the RAM have been armed, and which of two 4 KB banks fills `$D000-$DFFF`.

For every bus access the block produces a ROM select, a RAM read enable, a RAM write enable and a 14-bit physical RAM address. Both banks share the `$D000` page. `$E000-$FFFF` always maps to one common 8 KB area. Physical layout: the bank picked by switch address bit 3 clear sits at `0x0000-0x0FFF`, the bank picked by bit 3 set sits at `0x1000-0x1FFF`, and the common area sits at `0x2000-0x3FFF`.

A bus access may last several clock cycles. The block registers the previous access-valid level and treats only the first cycle of each access as a switch event. A held access therefore counts once.

Top module: `ramcard_ctrl`

## Requirements
- R1: After reset, window reads select ROM, RAM writes are fully armed, and the `$D000` page maps to the bank at physical `0x1000`.
- R2: A switch access whose address bits 1:0 equal 0 selects RAM for window reads and disarms RAM writes.
- R3: A switch access whose address bits 1:0 equal 2 selects ROM for window reads and disarms RAM writes.
- R4: A switch access with address bits 1:0 equal to 1 selects ROM for reads, and one equal to 3 selects RAM for reads. Either one advances a write-arm counter that goes disarmed, half-armed, armed and then stays at armed. RAM writes are enabled only when the counter is armed.
- R5: Every switch access loads the active `$D000` bank from address bit 3. Bit 3 clear gives physical base `0x0000` and bit 3 set gives `0x1000`.
- R6: A bus write cycle to a switch location performs the same action as a read cycle. Actions 1 and 3 never disarm the write counter.
- R7: An access held valid over several clock cycles changes the state once, at its first rising clock edge. The new state is visible from the next cycle onward.
- R8: When RAM is selected, reads of `$D000-$DFFF` assert `ram_rd_en` with address `{0, bank, A[11:0]}`, and reads of `$E000-$FFFF` assert it with address `{1, A[12:0]}`. Otherwise these reads assert `rom_sel` only.
- R9: When writes are armed, writes to `$D000-$FFFF` assert `ram_wr_en` with the same address mapping as R8. Otherwise they assert nothing.
- R10: A read cycle to a switch location drives `sw_hit` high with `sw_rdata` equal to zero. Switch addresses accessed with `card_sel` low leave the state unchanged.
- R11: Accesses below `$D000` never assert `rom_sel`, `ram_rd_en` or `ram_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access in progress; may span several cycles |
| bus_we | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | 16 | Processor address |
| card_sel | input | 1 | Access targets this card's soft-switch region |
| rom_sel | output | 1 | Read of the window served by ROM |
| ram_rd_en | output | 1 | Read of the window served by RAM |
| ram_wr_en | output | 1 | Write of the window stored into RAM |
| ram_addr | output | 14 | Physical RAM address |
| sw_hit | output | 1 | Soft-switch read cycle; drive `sw_rdata` |
| sw_rdata | output | 8 | Data returned on soft-switch reads (zero) |

## Verification
Two things can land in the same cycle: a switch action and an access to the overlay window. Also, the bank select and the write-arm step are both set by a single switch access. The bench runs every ordered pair of switch addresses, each as a read and as a write cycle. After each pair it probes reads and writes in the banked page, the common area and outside the window. Every probe is compared with a model that tracks the read source, arm count and bank. Held multi-cycle accesses and accesses with `card_sel` low are then run separately and must count once or not at all.

// File: rtl/ramcard_pkg.sv
package ramcard_pkg;

  typedef enum logic [1:0] {
    WR_OFF  = 2'd0,
    WR_HALF = 2'd1,
    WR_ON   = 2'd2
  } wr_arm_e;

  typedef enum logic [1:0] {
    ACT_RAM_NOWR = 2'd0,
    ACT_ROM_ARM  = 2'd1,
    ACT_ROM_NOWR = 2'd2,
    ACT_RAM_ARM  = 2'd3
  } sw_act_e;

endpackage

// File: rtl/ramcard_sw_decode.sv
module ramcard_sw_decode
  import ramcard_pkg::*;
#(
  parameter int SW_AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             card_sel,
  input  logic [SW_AW-1:0] sw_addr,
  output logic             acc_start,
  output logic             sw_fire,
  output sw_act_e          sw_act,
  output logic             sw_bank
);

  logic valid_q;
  logic valid_d;

  always_comb begin
    valid_d = bus_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // first cycle of an access only
  assign acc_start = bus_valid & ~valid_q;
  assign sw_fire   = acc_start & card_sel;
  assign sw_act    = sw_act_e'(sw_addr[1:0]);
  assign sw_bank   = sw_addr[3];

endmodule

// File: rtl/ramcard_state.sv
module ramcard_state
  import ramcard_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sw_fire,
  input  sw_act_e sw_act,
  input  logic    sw_bank,
  output logic    rd_ram_q,
  output wr_arm_e wr_arm_q,
  output logic    bank_q
);

  logic    rd_ram_d;
  wr_arm_e wr_arm_d;
  logic    bank_d;
  wr_arm_e arm_step;

  always_comb begin
    unique case (wr_arm_q)
      WR_OFF:  arm_step = WR_HALF;
      WR_HALF: arm_step = WR_ON;
      default: arm_step = WR_ON;
    endcase
  end

  always_comb begin
    rd_ram_d = rd_ram_q;
    wr_arm_d = wr_arm_q;
    bank_d   = bank_q;
    if (sw_fire) begin
      bank_d = sw_bank;
      unique case (sw_act)
        ACT_RAM_NOWR: begin rd_ram_d = 1'b1; wr_arm_d = WR_OFF;   end
        ACT_ROM_ARM:  begin rd_ram_d = 1'b0; wr_arm_d = arm_step; end
        ACT_ROM_NOWR: begin rd_ram_d = 1'b0; wr_arm_d = WR_OFF;   end
        default:      begin rd_ram_d = 1'b1; wr_arm_d = arm_step; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ram_q <= 1'b0;
      wr_arm_q <= WR_ON;
      bank_q   <= 1'b1;
    end else if (sw_fire) begin
      rd_ram_q <= rd_ram_d;
      wr_arm_q <= wr_arm_d;
      bank_q   <= bank_d;
    end
  end

endmodule

// File: rtl/ramcard_map.sv
module ramcard_map #(
  parameter int ADDR_W  = 16,
  parameter int BANK_AW = 12,
  parameter int RAM_AW  = BANK_AW + 2
) (
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              rd_ram,
  input  logic              wr_on,
  input  logic              bank,
  output logic              rom_sel,
  output logic              ram_rd_en,
  output logic              ram_wr_en,
  output logic [RAM_AW-1:0] ram_addr
);

  localparam int PAGE_W = ADDR_W - BANK_AW;
  localparam logic [PAGE_W-1:0] PG_LAST = '1;
  localparam logic [PAGE_W-1:0] PG_BANK = PG_LAST - 2'd2;

  logic [PAGE_W-1:0] page;
  logic              in_bank;
  logic              in_shared;
  logic              in_win;

  assign page      = bus_addr[ADDR_W-1:BANK_AW];
  assign in_bank   = (page == PG_BANK);
  assign in_shared = (page >= PG_LAST - 1'b1);
  assign in_win    = bus_valid & (in_bank | in_shared);

  assign rom_sel   = in_win & ~bus_we & ~rd_ram;
  assign ram_rd_en = in_win & ~bus_we &  rd_ram;
  assign ram_wr_en = in_win &  bus_we &  wr_on;

  always_comb begin
    if (in_bank) ram_addr = {1'b0, bank, bus_addr[BANK_AW-1:0]};
    else         ram_addr = {1'b1, bus_addr[BANK_AW:0]};
  end

endmodule

// File: rtl/ramcard_ctrl.sv
module ramcard_ctrl
  import ramcard_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int BANK_AW = 12,
  parameter int SW_AW   = 4,
  parameter int RAM_AW  = BANK_AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              card_sel,
  output logic              rom_sel,
  output logic              ram_rd_en,
  output logic              ram_wr_en,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              sw_hit,
  output logic [DATA_W-1:0] sw_rdata
);

  logic    acc_start;
  logic    sw_fire;
  sw_act_e sw_act;
  logic    sw_bank;
  logic    rd_ram_q;
  wr_arm_e wr_arm_q;
  logic    bank_q;

  ramcard_sw_decode #(.SW_AW(SW_AW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .card_sel  (card_sel),
    .sw_addr   (bus_addr[SW_AW-1:0]),
    .acc_start (acc_start),
    .sw_fire   (sw_fire),
    .sw_act    (sw_act),
    .sw_bank   (sw_bank)
  );

  ramcard_state u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_fire  (sw_fire),
    .sw_act   (sw_act),
    .sw_bank  (sw_bank),
    .rd_ram_q (rd_ram_q),
    .wr_arm_q (wr_arm_q),
    .bank_q   (bank_q)
  );

  ramcard_map #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .RAM_AW(RAM_AW)) u_map (
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .rd_ram    (rd_ram_q),
    .wr_on     (wr_arm_q == WR_ON),
    .bank      (bank_q),
    .rom_sel   (rom_sel),
    .ram_rd_en (ram_rd_en),
    .ram_wr_en (ram_wr_en),
    .ram_addr  (ram_addr)
  );

  assign sw_hit   = bus_valid & card_sel & ~bus_we;
  assign sw_rdata = '0;

endmodule

// File: rtl/ramcard_ctrl_chk.sv
module ramcard_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              card_sel,
  input logic              rom_sel,
  input logic              ram_rd_en,
  input logic              ram_wr_en,
  input logic              acc_start,
  input logic              rd_ram_q,
  input logic [1:0]        wr_arm_q,
  input logic              bank_q
);

  logic below_win;
  assign below_win = (bus_addr[ADDR_W-1:ADDR_W-4] < 4'hD);

  // R7: a held access leaves the state alone after its first edge
  a_r7_held_once: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !acc_start) |=> ($stable(wr_arm_q) && $stable(rd_ram_q) && $stable(bank_q)));

  // R4: the arm counter cannot jump from disarmed to armed
  a_r4_two_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_arm_q == 2'd0) |=> (wr_arm_q != 2'd2));

  // R4: counter never leaves its three legal states
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_arm_q != 2'd3);

  // R9: a RAM write needs the armed state
  a_r9_wr_armed: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> (wr_arm_q == 2'd2));

  // R8: ROM and RAM never both drive a read
  a_r8_rd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && ram_rd_en));

  // R6: an arming switch access never leaves the counter disarmed
  a_r6_arm_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && card_sel && bus_addr[0]) |=> (wr_arm_q != 2'd0));

  // R11: nothing selected below the window
  a_r11_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && below_win) |-> !(rom_sel || ram_rd_en || ram_wr_en));

endmodule

bind ramcard_ctrl ramcard_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .card_sel  (card_sel),
  .rom_sel   (rom_sel),
  .ram_rd_en (ram_rd_en),
  .ram_wr_en (ram_wr_en),
  .acc_start (acc_start),
  .rd_ram_q  (rd_ram_q),
  .wr_arm_q  (wr_arm_q),
  .bank_q    (bank_q)
);

// File: tb/tb_ramcard_ctrl.sv
module tb_ramcard_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        card_sel = 1'b0;
  logic        rom_sel, ram_rd_en, ram_wr_en, sw_hit;
  logic [13:0] ram_addr;
  logic [7:0]  sw_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model
  bit m_rd;
  int m_cnt;
  bit m_bank;

  ramcard_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .card_sel(card_sel), .rom_sel(rom_sel),
    .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .ram_addr(ram_addr),
    .sw_hit(sw_hit), .sw_rdata(sw_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_sw(input logic [3:0] a);
    m_bank = a[3];
    case (a[1:0])
      2'd0: begin m_rd = 1; m_cnt = 0; end
      2'd1: begin m_rd = 0; if (m_cnt < 2) m_cnt++; end
      2'd2: begin m_rd = 0; m_cnt = 0; end
      default: begin m_rd = 1; if (m_cnt < 2) m_cnt++; end
    endcase
  endfunction

  // switch access held for n cycles
  task automatic sw_access(input logic [3:0] a, input bit we, input int n, input bit sel);
    @(negedge clk);
    bus_valid = 1; bus_we = we; bus_addr = 16'hC080 | 16'(a); card_sel = sel;
    #1;
    chk("R10 sw_hit", {31'd0, sw_hit}, {31'd0, sel & ~we});
    chk("R10 sw_rdata", {24'd0, sw_rdata}, 32'd0);
    repeat (n) @(negedge clk);
    bus_valid = 0; card_sel = 0;
    if (sel) model_sw(a);
  endtask

  // one-cycle window probe, compared with the model
  task automatic probe(input logic [15:0] a, input bit we, input string req);
    bit win, exp_rom, exp_rd, exp_wr;
    logic [13:0] exp_addr;
    @(negedge clk);
    bus_valid = 1; bus_we = we; bus_addr = a; card_sel = 0;
    #1;
    win = (a[15:12] >= 4'hD);
    exp_rom = win & ~we & ~m_rd;
    exp_rd  = win & ~we & m_rd;
    exp_wr  = win & we & (m_cnt == 2);
    if (a[15:12] == 4'hD) exp_addr = {1'b0, m_bank, a[11:0]};
    else                  exp_addr = {1'b1, a[12:0]};
    chk({req, " rom_sel"}, {31'd0, rom_sel}, {31'd0, exp_rom});
    chk({req, " ram_rd_en"}, {31'd0, ram_rd_en}, {31'd0, exp_rd});
    chk({req, " ram_wr_en"}, {31'd0, ram_wr_en}, {31'd0, exp_wr});
    if (exp_rd | exp_wr) chk({req, " ram_addr"}, {18'd0, ram_addr}, {18'd0, exp_addr});
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic probe_all(input logic [11:0] off);
    probe({4'hD, off}, 0, "R8 bank read");
    probe({4'hD, off}, 1, "R9 bank write");
    probe({4'hE, off}, 0, "R8 shared read");
    probe({4'hF, off}, 1, "R9 shared write");
    probe({4'hF, ~off}, 0, "R8 shared read high");
    probe({4'h8, off}, 1, "R11 outside write");
    probe({4'hC, off}, 0, "R11 outside read");
  endtask

  initial begin
    m_rd = 0; m_cnt = 2; m_bank = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    probe(16'hD123, 0, "R1 reset read");
    probe(16'hD123, 1, "R1 reset write");
    probe(16'hE777, 1, "R1 reset shared write");

    // R2 R3 R4 R5 R6: all ordered pairs of switch accesses, read and write cycles
    for (int p = 0; p < 16; p++) begin
      for (int s = 0; s < 16; s++) begin
        for (int w = 0; w < 2; w++) begin
          sw_access(4'(p), 0, 1, 1);
          sw_access(4'(s), w[0], 1, 1);
          probe_all({4'(p), 4'(s), 3'h5, w[0]});
        end
      end
    end

    // R7 held access counts once
    sw_access(4'h2, 0, 1, 1);
    sw_access(4'h1, 0, 5, 1);
    probe(16'hF00F, 1, "R7 held arm once");
    sw_access(4'h9, 1, 4, 1);
    probe(16'hD00F, 1, "R7 second arm");

    // R10 card_sel low: no action
    sw_access(4'hA, 0, 1, 1);
    sw_access(4'h3, 0, 1, 0);
    sw_access(4'h3, 1, 1, 0);
    probe(16'hE010, 1, "R10 unselected no arm");
    probe(16'hE010, 0, "R10 unselected no read change");

    // R6: write cycle keeps partial arming
    sw_access(4'h0, 0, 1, 1);
    sw_access(4'hB, 1, 1, 1);
    sw_access(4'h3, 1, 1, 1);
    probe(16'hDFFF, 1, "R6 write cycles arm");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule